// File: doc/BRIEF.md
# Generation-Bit Event Queue

This block is a circular queue of 32-bit notification words held in a memory whose depth is a power of two. A producer port stores each nonzero event number together with a one-bit generation marker. The marker the producer writes inverts every time its write position passes the last slot and returns to slot 0.

A consumer port always presents the word at its own read position. The word counts as a pending event only when its marker differs from the consumer's local phase bit. A pop takes the pending event and moves the read position forward. The phase bit inverts whenever the read position returns to slot 0.

No head or tail pointer is shared between the two sides. Emptiness is decided word by word, by comparing the stored marker with the consumer's phase. The memory and the phase both start at zero, and the producer starts with marker 1. Because of this, a freshly reset queue reads as empty. Overrun protection is not part of the block and is left to the system around it.

Top module: `evq_top`

## Requirements
- R1: After reset the queue reports empty: `empty` is 1, `head_event` is 0 and `head_ipi` is 0.
- R2: A stored word carries the marker in bit 31 and the event number in bits 30:0. `head_event` presents bits 30:0 of the word at the read position whenever that word is pending.
- R3: The producer writes marker 1 during its first pass through the memory. The marker inverts each time the write position wraps from DEPTH-1 to 0.
- R4: A word whose marker equals the consumer phase is not pending. In that case `empty` is 1 and `head_event` is 0.
- R5: A pop while a word is pending advances the read position by one. A pop while empty changes nothing.
- R6: The consumer phase starts at 0 and inverts each time the read position wraps from DEPTH-1 to 0.
- R7: A push whose event number is 0 is dropped. Nothing is written and the write position does not move.
- R8: When a push lands on the slot at the read position, the consumer sees the old word in that cycle. The new event appears one clock later.
- R9: `head_ipi` is 1 exactly when a pending event equals 2^24, the reserved inter-processor code.
- R10: Events are popped in push order across repeated wraps of the memory, provided no more than DEPTH events are ever outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Producer write request |
| push_event | input | 31 | Event number to store |
| pop | input | 1 | Consumer take request |
| head_event | output | 31 | Pending event at the read position, 0 when empty |
| head_ipi | output | 1 | Pending event is the inter-processor code |
| empty | output | 1 | No pending event at the read position |

## Verification
A wrong write marker or a wrong consumer phase shows up at the ports as a full pass of pending events that reads as empty, or as stale words from the previous pass that reappear as events. The bench exposes this by draining the memory to exactly one slot past each wrap. It does so over several consecutive passes, so any such fault appears within DEPTH pops of the bad wrap. A read or write position that drifts shows up on the next `head_event` as an out-of-order or missing event. This is compared after every push and every pop.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int ENTRY_W = 32;
    localparam int EVT_W   = ENTRY_W - 1;
    localparam logic [EVT_W-1:0] IPI_EVENT = EVT_W'(32'h0100_0000);

    typedef struct packed {
        logic             gen;
        logic [EVT_W-1:0] evt;
    } evq_word_t;
endpackage

// File: rtl/evq_producer.sv
module evq_producer
    import evq_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [EVT_W-1:0]         push_event,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output evq_word_t                wr_word
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic          gen;
    } prod_t;

    prod_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wr_en   = push && (push_event != '0);
        wr_addr = st_q.idx;
        wr_word = '{gen: st_q.gen, evt: push_event};
        if (wr_en) begin
            st_d.idx = st_q.idx + AW'(1);
            if (st_q.idx == LAST) begin
                st_d.gen = ~st_q.gen;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, gen: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    p_gen_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_event != '0 && wr_addr == LAST) |=> (wr_word.gen != $past(wr_word.gen)));
    p_gen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_event != '0 && wr_addr != LAST) |=> $stable(wr_word.gen));
    p_zero_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_event == '0) |=> $stable(wr_addr));
endmodule

// File: rtl/evq_ram.sv
module evq_ram
    import evq_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  evq_word_t                wr_word,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output evq_word_t                rd_word
);
    evq_word_t mem_q [DEPTH];

    // Read is combinational from the registered array: a same-cycle write
    // lands at the edge, so the reader sees the previous word (R8).
    assign rd_word = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_word;
        end
    end
endmodule

// File: rtl/evq_consumer.sv
module evq_consumer
    import evq_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pop,
    input  evq_word_t                rd_word,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [EVT_W-1:0]         head_event,
    output logic                     head_ipi,
    output logic                     empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic          tgl;
    } cons_t;

    cons_t st_d, st_q;
    logic  pending;

    always_comb begin
        st_d       = st_q;
        rd_addr    = st_q.idx;
        pending    = (rd_word.gen != st_q.tgl);
        empty      = !pending;
        head_event = pending ? rd_word.evt : '0;
        head_ipi   = pending && (rd_word.evt == IPI_EVENT);
        if (pop && pending) begin
            st_d.idx = st_q.idx + AW'(1);
            if (st_q.idx == LAST) begin
                st_d.tgl = ~st_q.tgl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (head_event == '0 && !head_ipi));
    p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> ($stable(rd_addr) && $stable(st_q.tgl)));
    p_tgl_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && rd_addr == LAST) |=> (st_q.tgl != $past(st_q.tgl) && rd_addr == '0));
    p_ipi_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        head_ipi |-> !empty);
endmodule

// File: rtl/evq_top.sv
module evq_top
    import evq_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [EVT_W-1:0] push_event,
    input  logic             pop,
    output logic [EVT_W-1:0] head_event,
    output logic             head_ipi,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    evq_word_t     wr_word;
    evq_word_t     rd_word;

    evq_producer #(.DEPTH(DEPTH)) u_prod (
        .clk(clk), .rst_n(rst_n), .push(push), .push_event(push_event),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word)
    );

    evq_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_word(wr_word), .rd_addr(rd_addr), .rd_word(rd_word)
    );

    evq_consumer #(.DEPTH(DEPTH)) u_cons (
        .clk(clk), .rst_n(rst_n), .pop(pop), .rd_word(rd_word),
        .rd_addr(rd_addr), .head_event(head_event), .head_ipi(head_ipi),
        .empty(empty)
    );

    p_push_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && push && push_event != '0 && wr_addr == rd_addr && !pop)
        |=> (!empty && head_event == $past(push_event)));
endmodule

// File: tb/evq_top_tb.sv
module evq_top_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0;
    logic [30:0] push_event = '0;
    logic        pop = 1'b0;
    logic [30:0] head_event;
    logic        head_ipi;
    logic        empty;

    int n_chk = 0;
    int n_bad = 0;
    int model [$];

    always #5 clk = ~clk;

    evq_top #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .push(push), .push_event(push_event),
        .pop(pop), .head_event(head_event), .head_ipi(head_ipi), .empty(empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_head(input string req);
        logic [30:0] e;
        e = (model.size() > 0) ? 31'(model[0]) : '0;
        chk(req, {1'b0, head_event}, {1'b0, e});
        chk(req, {31'b0, empty}, {31'b0, model.size() == 0});
    endtask

    // One clock: inputs set 1 ns after an edge, cleared 1 ns after the next.
    task automatic step(input logic p, input logic [30:0] ev, input logic q);
        push = p; push_event = ev; pop = q;
        @(posedge clk); #1;
        push = 1'b0; push_event = '0; pop = 1'b0;
        if (q && model.size() > 0) void'(model.pop_front());
        if (p && ev != '0) model.push_back(int'(ev));
    endtask

    task automatic t_reset;
        chk("R1 empty", {31'b0, empty}, 32'd1);
        chk("R1 head", {1'b0, head_event}, 32'd0);
        chk("R1 ipi", {31'b0, head_ipi}, 32'd0);
    endtask

    task automatic t_pop_empty;
        step(1'b0, '0, 1'b1);
        chk_head("R5 pop while empty");
        step(1'b1, 31'd42, 1'b0);
        chk_head("R5 after push");
        step(1'b0, '0, 1'b1);
        chk_head("R5 after pop");
    endtask

    task automatic t_zero_push;
        step(1'b1, 31'd0, 1'b0);
        chk_head("R7 zero dropped");
        step(1'b1, 31'd5, 1'b0);
        chk_head("R7 next push lands at read slot");
        step(1'b0, '0, 1'b1);
        chk_head("R7 drained");
    endtask

    task automatic t_same_cycle;
        push = 1'b1; push_event = 31'd77;
        #2;
        chk("R8 old word seen", {31'b0, empty}, 32'd1);
        chk("R8 old head", {1'b0, head_event}, 32'd0);
        @(posedge clk); #1;
        push = 1'b0; push_event = '0;
        model.push_back(77);
        chk_head("R8 new word next cycle");
        step(1'b0, '0, 1'b1);
        chk_head("R8 drained");
    endtask

    task automatic t_ipi;
        step(1'b1, 31'h0100_0000, 1'b0);
        chk("R9 ipi flag", {31'b0, head_ipi}, 32'd1);
        chk_head("R9 ipi value R2");
        step(1'b1, 31'h0100_0001, 1'b1);
        chk("R9 non-ipi", {31'b0, head_ipi}, 32'd0);
        chk_head("R9 head");
        step(1'b0, '0, 1'b1);
        chk("R9 empty ipi low", {31'b0, head_ipi}, 32'd0);
    endtask

    task automatic t_wraps;
        for (int w = 0; w < 4; w++) begin
            for (int i = 0; i < DEPTH; i++) begin
                step(1'b1, 31'(w * 100 + i + 1), 1'b0);
                chk_head("R3 R10 fill");
            end
            for (int i = 0; i < DEPTH; i++) begin
                step(1'b0, '0, 1'b1);
                chk_head("R6 R10 drain");
            end
        end
        for (int i = 0; i < 3; i++) step(1'b1, 31'(500 + i), 1'b0);
        for (int i = 0; i < 3 * DEPTH; i++) begin
            step(1'b1, 31'(600 + i), 1'b1);
            chk_head("R10 streaming R2");
        end
        for (int i = 0; i < 3; i++) begin
            step(1'b0, '0, 1'b1);
            chk_head("R4 R10 tail");
        end
        step(1'b0, '0, 1'b1);
        chk_head("R4 stale words not pending");
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_pop_empty();
        t_zero_push();
        t_same_cycle();
        t_ipi();
        t_wraps();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule